// File: doc/BRIEF.md
# Masked Hardware Breakpoint Comparator

This block watches the processor's instruction fetch bus and its load/store bus. It raises a break request in the same cycle as an access that one of its armed channels selects. The request reaches the core before the access commits, so the trapped fetch, load or store changes no register or memory state. The low channels are instruction channels and watch virtual fetch addresses. The upper channels are data channels and watch load/store addresses, with an optional compare on the transferred value.

A channel compares the address under a per-bit ignore mask, so one channel can cover an aligned range. It can also require an exact address-space ID. A data channel is further qualified by direction and can compare the data value under its own ignore mask. A load's data only arrives in its return cycle, so a load with a value compare fires in that cycle and not in the request cycle. While the debug-mode input is high, nothing fires. Channels can be set up in debug mode and take effect once it drops, or they can be set up while running. A write port sets up the channels; each channel keeps a sticky hit flag that software clears by writing 1 to it.

Top module: `hw_brk_cmp`

## Requirements
- R1: An enabled instruction channel asserts `brk_req` combinationally in the cycle where `if_valid` is high and the fetch address matches its address register on all unmasked bits. A mismatching address gives no request, and `brk_req` is high only in a cycle with a fetch, a load/store request or a load return.
- R2: With the ASID-qualify bit (control bit 1) set, a channel also requires the access's ASID to equal control bits [ASW+7:8]. With the bit clear, the ASID is ignored.
- R3: A mask bit of 1 removes that address bit from the comparison. A fully masked, enabled channel matches every qualifying access.
- R4: A data channel fires on loads only if control bit 2 is set, and on stores only if control bit 3 is set. With both bits set it fires on either.
- R5: With the value-compare bit (control bit 4) set, a data channel fires on a store only if the store data matches its data register on all bits whose data-mask bit is 0. It fires in the request cycle.
- R6: A load that meets the address, ASID and direction conditions of a value-comparing channel gives no request in its request cycle. It raises `brk_req` in the next cycle with `ld_rvalid` high, but only if `ld_rdata` matches under the data mask. A return with no such load pending raises nothing.
- R7: A channel whose enable bit (control bit 0) is 0 never fires.
- R8: While `dbg_mode` is high, `brk_req` stays low, no hit flag is set, and a pending load compare does not fire. A channel armed during debug mode takes effect on the first access after `dbg_mode` falls.
- R9: `hit_sts[c]` is set in the cycle after channel c fires. It holds until a configuration write to that channel's status field with bit 0 set clears it.
- R10: After reset all channels are disabled, every `hit_sts` bit is 0 and `brk_req` is 0. Configuration writes use `cfg_addr = {channel, field}`, where field is 3 bits: 0 control, 1 address, 2 address mask, 3 data, 4 data mask, 5 status (write 1 to clear). Channels 0..NI-1 are instruction channels and the rest are data channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbg_mode | input | 1 | Core is in debug mode; suppresses all matches |
| if_valid | input | 1 | Fetch request this cycle |
| if_addr | input | AW | Virtual fetch address |
| if_asid | input | ASW | ASID of the fetch |
| ls_valid | input | 1 | Load/store request this cycle |
| ls_write | input | 1 | 1 for a store, 0 for a load |
| ls_addr | input | AW | Virtual load/store address |
| ls_asid | input | ASW | ASID of the load/store |
| ls_wdata | input | DW | Store data |
| ld_rvalid | input | 1 | Load data returns this cycle |
| ld_rdata | input | DW | Returned load data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CW+3 | Channel index and field select |
| cfg_wdata | input | RW | Configuration write data |
| hit_sts | output | NI+ND | Sticky per-channel hit flags |
| brk_req | output | 1 | Break request for the current access |

## Verification
Instruction channels are driven with exact hits and with addresses one word off. Masked ranges are driven with addresses inside and just outside the range, which separates masked bits from compared ones. Matching and differing ASIDs, with the qualifier on and off, show whether the ID is really used. Data channels get loads and stores under each direction setting, and stores whose data differs only in unmasked bits. Loads with a value compare get matching and mismatching return data and an address miss. This shows that the break moves to the return cycle and depends on the returned value. Runs with debug mode set, including a load return during debug mode, check the suppression. Status reads check that the hit flags stay set and that the write-1 clear works.

// File: rtl/hw_brk_cmp.sv
module hw_brk_cmp #(
  parameter int NI  = 2,
  parameter int ND  = 2,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int ASW = 8,
  localparam int NCH = NI + ND,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RW  = (AW > DW) ? AW : DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic              if_valid,
  input  logic [AW-1:0]     if_addr,
  input  logic [ASW-1:0]    if_asid,
  input  logic              ls_valid,
  input  logic              ls_write,
  input  logic [AW-1:0]     ls_addr,
  input  logic [ASW-1:0]    ls_asid,
  input  logic [DW-1:0]     ls_wdata,
  input  logic              ld_rvalid,
  input  logic [DW-1:0]     ld_rdata,
  input  logic              cfg_we,
  input  logic [CW+2:0]     cfg_addr,
  input  logic [RW-1:0]     cfg_wdata,
  output logic [NCH-1:0]    hit_sts,
  output logic              brk_req
);
  localparam logic [2:0] F_CTRL = 3'd0, F_ADDR = 3'd1, F_AMSK = 3'd2,
                         F_DATA = 3'd3, F_DMSK = 3'd4, F_STS = 3'd5;

  logic [NCH-1:0] en_q, asen_q, onld_q, onst_q, dcmp_q, fire, clr;
  logic [ASW-1:0] asid_q [NCH];
  logic [AW-1:0]  addr_q [NCH];
  logic [AW-1:0]  amsk_q [NCH];
  logic [DW-1:0]  data_q [NCH];
  logic [DW-1:0]  dmsk_q [NCH];

  wire [CW-1:0] wch  = cfg_addr[CW+2:3];
  wire [2:0]    wfld = cfg_addr[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; asen_q <= '0; onld_q <= '0; onst_q <= '0; dcmp_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        asid_q[c] <= '0; addr_q[c] <= '0; amsk_q[c] <= '0;
        data_q[c] <= '0; dmsk_q[c] <= '0;
      end
    end else if (cfg_we && int'(wch) < NCH) begin
      case (wfld)
        F_CTRL: begin
          en_q[wch]   <= cfg_wdata[0];
          asen_q[wch] <= cfg_wdata[1];
          onld_q[wch] <= cfg_wdata[2];
          onst_q[wch] <= cfg_wdata[3];
          dcmp_q[wch] <= cfg_wdata[4];
          asid_q[wch] <= cfg_wdata[ASW+7:8];
        end
        F_ADDR:  addr_q[wch] <= cfg_wdata[AW-1:0];
        F_AMSK:  amsk_q[wch] <= cfg_wdata[AW-1:0];
        F_DATA:  data_q[wch] <= cfg_wdata[DW-1:0];
        F_DMSK:  dmsk_q[wch] <= cfg_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign clr[g] = cfg_we && wfld == F_STS && int'(wch) == g && cfg_wdata[0];

    if (g < NI) begin : g_inst
      wire a_ok = ((if_addr ^ addr_q[g]) & ~amsk_q[g]) == '0;
      wire s_ok = !asen_q[g] || if_asid == asid_q[g];
      assign fire[g] = en_q[g] && !dbg_mode && if_valid && a_ok && s_ok;
    end else begin : g_data
      logic pend;
      wire a_ok   = ((ls_addr ^ addr_q[g]) & ~amsk_q[g]) == '0;
      wire s_ok   = !asen_q[g] || ls_asid == asid_q[g];
      wire dir_ok = ls_write ? onst_q[g] : onld_q[g];
      wire req_ok = en_q[g] && !dbg_mode && ls_valid && dir_ok && a_ok && s_ok;
      wire wd_ok  = ((ls_wdata ^ data_q[g]) & ~dmsk_q[g]) == '0;
      wire rd_ok  = ((ld_rdata ^ data_q[g]) & ~dmsk_q[g]) == '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               pend <= 1'b0;
        else if (req_ok && dcmp_q[g] && !ls_write) pend <= 1'b1;
        else if (ld_rvalid)                       pend <= 1'b0;
      end

      assign fire[g] = (req_ok && (!dcmp_q[g] || (ls_write && wd_ok)))
                    || (pend && en_q[g] && !dbg_mode && ld_rvalid && rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_sts <= '0;
    else        hit_sts <= (hit_sts & ~clr) | fire;
  end

  assign brk_req = |fire;
endmodule

// File: rtl/brk_cmp_chk.sv
module brk_cmp_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dbg_mode,
  input logic           if_valid,
  input logic           ls_valid,
  input logic           ld_rvalid,
  input logic           cfg_we,
  input logic [NCH-1:0] hit_sts,
  input logic           brk_req
);
  AST_REQ_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (if_valid || ls_valid || ld_rvalid)); // R1
  AST_NO_BRK_IN_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |-> !brk_req); // R8
  AST_NO_NEW_STS_IN_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |=> ((hit_sts & ~$past(hit_sts)) == '0)); // R8
  AST_STS_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> (hit_sts != '0)); // R9
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ((hit_sts & $past(hit_sts)) == $past(hit_sts))); // R9
  AST_STS_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!brk_req) |-> ((hit_sts & ~$past(hit_sts)) == '0)); // R9
endmodule

bind hw_brk_cmp brk_cmp_chk #(.NCH(NCH)) i_chk (
  .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .if_valid(if_valid),
  .ls_valid(ls_valid), .ld_rvalid(ld_rvalid), .cfg_we(cfg_we),
  .hit_sts(hit_sts), .brk_req(brk_req)
);

// File: tb/test_hw_brk_cmp.sv
`timescale 1ns/1ps
module test_hw_brk_cmp;
  localparam int NCH = 4;

  logic clk = 1'b0, rst_n = 1'b0, dbg_mode = 1'b0;
  logic if_valid = 1'b0, ls_valid = 1'b0, ls_write = 1'b0, ld_rvalid = 1'b0, cfg_we = 1'b0;
  logic [31:0] if_addr = '0, ls_addr = '0, ls_wdata = '0, ld_rdata = '0, cfg_wdata = '0;
  logic [7:0]  if_asid = '0, ls_asid = '0;
  logic [4:0]  cfg_addr = '0;
  logic [NCH-1:0] hit_sts;
  logic brk_req;

  hw_brk_cmp i_hw_brk_cmp (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
    .if_valid(if_valid), .if_addr(if_addr), .if_asid(if_asid),
    .ls_valid(ls_valid), .ls_write(ls_write), .ls_addr(ls_addr), .ls_asid(ls_asid),
    .ls_wdata(ls_wdata), .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hit_sts(hit_sts), .brk_req(brk_req)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit            req;
    bit            chk;
    logic [NCH-1:0] sts;
    string         tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit dbg_r = 1'b0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (brk_req !== it.req) begin
        fails++;
        $display("FAIL %s brk_req actual=%b expected=%b", it.tag, brk_req, it.req);
      end
      if (it.chk) begin
        checks++;
        if (hit_sts !== it.sts) begin
          fails++;
          $display("FAIL %s hit_sts actual=%b expected=%b", it.tag, hit_sts, it.sts);
        end
      end
    end
  end

  task automatic cyc(input bit iv, input logic [31:0] ia, input logic [7:0] ias,
                     input bit lv, input bit lw, input logic [31:0] la, input logic [7:0] las,
                     input logic [31:0] ld, input bit rv, input logic [31:0] rd,
                     input bit we, input logic [4:0] ca, input logic [31:0] cd,
                     input bit er, input bit ck, input logic [NCH-1:0] es, input string t);
    item_t it;
    @(posedge clk); #1;
    dbg_mode = dbg_r;
    if_valid = iv; if_addr = ia; if_asid = ias;
    ls_valid = lv; ls_write = lw; ls_addr = la; ls_asid = las; ls_wdata = ld;
    ld_rvalid = rv; ld_rdata = rd;
    cfg_we = we; cfg_addr = ca; cfg_wdata = cd;
    it.req = er; it.chk = ck; it.sts = es; it.tag = t;
    q.push_back(it);
  endtask

  task automatic idle(input bit ck, input logic [NCH-1:0] es, input string t);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ck, es, t);
  endtask
  task automatic cfg(input int ch, input int fld, input logic [31:0] d);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'(ch * 8 + fld), d, 0, 0, 0, "R7");
  endtask
  task automatic fetch(input logic [31:0] a, input logic [7:0] s, input bit er, input string t);
    cyc(1, a, s, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, er, 0, 0, t);
  endtask
  task automatic lsop(input bit w, input logic [31:0] a, input logic [7:0] s,
                      input logic [31:0] d, input bit er, input string t);
    cyc(0, 0, 0, 1, w, a, s, d, 0, 0, 0, 0, 0, er, 0, 0, t);
  endtask
  task automatic ret(input logic [31:0] d, input bit er, input string t);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, d, 0, 0, 0, er, 0, 0, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1, 4'b0000, "R10");
    fetch(32'h1000_0040, 0, 0, "R7");

    cfg(0, 1, 32'h1000_0040);
    cfg(0, 0, 32'h1);
    fetch(32'h1000_0040, 0, 1, "R1");
    fetch(32'h1000_0044, 0, 0, "R1");
    idle(1, 4'b0001, "R9");
    idle(1, 4'b0001, "R9");
    cfg(0, 5, 32'h1);
    idle(1, 4'b0000, "R9");

    cfg(1, 1, 32'h2000_0000);
    cfg(1, 2, 32'h0000_00FF);
    cfg(1, 0, 32'h5A03);
    fetch(32'h2000_00F3, 8'h5A, 1, "R3");
    fetch(32'h2000_01F3, 8'h5A, 0, "R3");
    fetch(32'h2000_0010, 8'h5B, 0, "R2");
    cfg(1, 0, 32'h5A01);
    fetch(32'h2000_0010, 8'h5B, 1, "R2");

    cfg(0, 0, 32'h0);
    fetch(32'h1000_0040, 0, 0, "R7");
    cfg(1, 2, 32'hFFFF_FFFF);
    fetch(32'hDEAD_BEEC, 8'h11, 1, "R3");
    cfg(1, 0, 32'h0);
    fetch(32'hDEAD_BEEC, 8'h11, 0, "R7");

    cfg(2, 1, 32'h3000_0100);
    cfg(2, 0, 32'h5);
    lsop(1, 32'h3000_0100, 0, 0, 0, "R4");
    lsop(0, 32'h3000_0100, 0, 0, 1, "R4");
    cfg(2, 0, 32'h9);
    lsop(0, 32'h3000_0100, 0, 0, 0, "R4");
    lsop(1, 32'h3000_0100, 0, 0, 1, "R4");
    cfg(2, 0, 32'hD);
    lsop(0, 32'h3000_0100, 0, 0, 1, "R4");
    lsop(1, 32'h3000_0100, 0, 0, 1, "R4");

    cfg(2, 3, 32'hCAFE_0000);
    cfg(2, 4, 32'h0000_FFFF);
    cfg(2, 0, 32'h19);
    lsop(1, 32'h3000_0100, 0, 32'hCAFE_1234, 1, "R5");
    lsop(1, 32'h3000_0100, 0, 32'hCAFF_1234, 0, "R5");
    cfg(2, 0, 32'h0);

    cfg(3, 1, 32'h4000_0000);
    cfg(3, 3, 32'h1234_5678);
    cfg(3, 0, 32'h15);
    lsop(1, 32'h4000_0000, 0, 32'h1234_5678, 0, "R4");
    lsop(0, 32'h4000_0000, 0, 0, 0, "R6");
    idle(0, 0, "R6");
    ret(32'h1234_5678, 1, "R6");
    lsop(0, 32'h4000_0000, 0, 0, 0, "R6");
    ret(32'h1234_5679, 0, "R6");
    lsop(0, 32'h4000_0004, 0, 0, 0, "R6");
    ret(32'h1234_5678, 0, "R6");
    ret(32'h1234_5678, 0, "R6");

    for (int c = 0; c < NCH; c++) cfg(c, 5, 32'h1);
    idle(1, 4'b0000, "R9");

    dbg_r = 1'b1;
    cfg(0, 0, 32'h1);
    fetch(32'h1000_0040, 0, 0, "R8");
    lsop(0, 32'h4000_0000, 0, 0, 0, "R8");
    ret(32'h1234_5678, 0, "R8");
    idle(1, 4'b0000, "R8");
    dbg_r = 1'b0;
    fetch(32'h1000_0040, 0, 1, "R8");
    idle(1, 4'b0001, "R9");
    lsop(0, 32'h4000_0000, 0, 0, 0, "R6");
    dbg_r = 1'b1;
    ret(32'h1234_5678, 0, "R8");
    dbg_r = 1'b0;
    idle(1, 4'b0001, "R8");

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule